// File: doc/BRIEF.md
# Parallel Printer Port Strobe Engine

This block sits between a small register bus and the output pins of a Centronics-style printer port. Software writes a byte to the data location. The block latches the byte onto the eight data lines and, in automatic mode, issues an active-low strobe pulse of one of two fixed widths. The data lines hold their value for the whole pulse. In manual mode the automatic timer is idle and a control bit drives the strobe level directly. A second control bit drives the input-prime output to the printer.

Reading the data location returns the printer's five status lines. They pass through synchronising flops first, and each sits at a fixed bit position. Reading the control location returns the four control bits. Both pulse widths are defined in nanoseconds and are converted into clock cycles from a clock-frequency parameter.

Bus map: `bus_addr` = 0 is the data location, written as the byte to print and read as status. `bus_addr` = 1 is the control location.

Top module: `pport_strobe_top`

## Requirements
- R1: After reset, `strobe_n` is 1, `prime_o` is 0, `pdata` is 0x00, and a control read returns 0x00. This means automatic mode with the long pulse width.
- R2: In automatic mode (control bit 0 = 0), a write to address 0 loads `bus_wdata` onto `pdata` and drives `strobe_n` low on the same clock edge.
- R3: With control bit 1 = 0, the automatic strobe stays low for exactly CLK_HZ × 6400 ns / 1e9 clock cycles and then returns high.
- R4: With control bit 1 = 1, the automatic strobe stays low for exactly CLK_HZ × 1600 ns / 1e9 clock cycles.
- R5: A data write that arrives while an automatic strobe is low is accepted. It replaces `pdata` and restarts the full pulse width from that write.
- R6: With control bit 0 = 1, `strobe_n` equals the inverse of control bit 2 from the edge after the control write. Data writes still update `pdata` but produce no pulse. Entering manual mode cancels any automatic pulse in progress.
- R7: `prime_o` follows control bit 3 from the edge of the control write.
- R8: A read of address 0 returns the synchronised status lines in these positions: busy at bit 3, paper-empty at bit 4, select at bit 5, fault at bit 6, ack at bit 7. Bits 2:0 read as 0.
- R9: A read of address 1 returns the four control bits in bits 3:0, with bits 7:4 as 0. Read data is registered and valid from the edge after the read request.
- R10: While `strobe_n` is low and no new data write occurs, `pdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data/status, 1 = control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| prn_busy | input | 1 | Printer busy line |
| prn_paper_empty | input | 1 | Printer out-of-paper line |
| prn_select | input | 1 | Printer selected line |
| prn_fault | input | 1 | Printer fault line |
| prn_ack | input | 1 | Printer acknowledge line |
| pdata | output | 8 | Printer data lines |
| strobe_n | output | 1 | Active-low data strobe |
| prime_o | output | 1 | Input-prime output, active high |

## Verification
The bench builds the block with CLK_HZ = 10,000,000. At that value the two pulses last 64 and 16 cycles, so the bench can measure both widths exactly, edge by edge, in a short run. It can also retrigger a pulse in mid-flight and leave enough cycles on either side to show that the full width restarts. SYNC_STAGES keeps its default of 2, and the bench waits past that latency before each status read.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam int DATA_W    = 8;
  localparam int STATUS_N  = 5;
  localparam int STATUS_LSB = 3;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic prime;       // bit 3
    logic man_level;   // bit 2
    logic fast;        // bit 1
    logic manual;      // bit 0
  } pport_ctrl_t;

  function automatic int ns_to_cycles(input longint unsigned clk_hz,
                                      input longint unsigned ns);
    longint unsigned c;
    c = (clk_hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pport_status_sync.sv
module pport_status_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic [STATUS_N-1:0] status_i,
  output logic [DW-1:0]       bus_rdata,
  output pport_ctrl_t         ctrl_q,
  output logic [DW-1:0]       data_q,
  output logic                data_wr
);

  localparam int CTRL_W = $bits(pport_ctrl_t);

  logic ctrl_wr;
  logic rd_req;

  assign data_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
  assign ctrl_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_req  = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= pport_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (data_wr) begin
      data_q <= bus_wdata;
    end
  end

  logic [DW-1:0] status_word;
  logic [DW-1:0] ctrl_word;

  always_comb begin
    status_word = '0;
    status_word[STATUS_LSB +: STATUS_N] = status_i;
    ctrl_word = '0;
    ctrl_word[CTRL_W-1:0] = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      bus_rdata <= (bus_addr == ADDR_DATA) ? status_word : ctrl_word;
    end
  end

endmodule

// File: rtl/pport_strobe_gen.sv
module pport_strobe_gen #(
  parameter int SLOW_CYC = 64,
  parameter int FAST_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fast_sel,
  input  logic manual,
  input  logic man_level,
  output logic strobe_n
);

  localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(SLOW_CYC);
  localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_CYC);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_n <= 1'b1;
    end else if (manual) begin
      cnt_q    <= '0;
      strobe_n <= ~man_level;
    end else if (start) begin
      cnt_q    <= fast_sel ? FAST_LOAD : SLOW_LOAD;
      strobe_n <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - ONE;
      strobe_n <= !(cnt_q > ONE);
    end
  end

endmodule

// File: rtl/pport_strobe_top.sv
module pport_strobe_top
  import pport_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SLOW_NS     = 6400,
  parameter int FAST_NS     = 1600,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       prn_busy,
  input  logic       prn_paper_empty,
  input  logic       prn_select,
  input  logic       prn_fault,
  input  logic       prn_ack,
  output logic [7:0] pdata,
  output logic       strobe_n,
  output logic       prime_o
);

  localparam int SLOW_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(SLOW_NS));
  localparam int FAST_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(FAST_NS));

  logic [STATUS_N-1:0] status_raw;
  logic [STATUS_N-1:0] status_sync;
  pport_ctrl_t         ctrl_q;
  logic [DATA_W-1:0]   data_q;
  logic                data_wr;
  logic                auto_start;

  // order sets bit positions 3..7 of the status word
  assign status_raw = {prn_ack, prn_fault, prn_select, prn_paper_empty, prn_busy};

  pport_status_sync #(
    .WIDTH  (STATUS_N),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (status_raw),
    .sync_o  (status_sync)
  );

  pport_regs #(
    .DW (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_i  (status_sync),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .data_q    (data_q),
    .data_wr   (data_wr)
  );

  assign auto_start = data_wr && !ctrl_q.manual;

  pport_strobe_gen #(
    .SLOW_CYC (SLOW_CYC),
    .FAST_CYC (FAST_CYC)
  ) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .start     (auto_start),
    .fast_sel  (ctrl_q.fast),
    .manual    (ctrl_q.manual),
    .man_level (ctrl_q.man_level),
    .strobe_n  (strobe_n)
  );

  assign pdata   = data_q;
  assign prime_o = ctrl_q.prime;

endmodule

// File: rtl/pport_strobe_checker.sv
module pport_strobe_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] pdata,
  input logic       strobe_n,
  input logic       prime_o,
  input logic       mode_manual
);

  logic data_wr_c;
  logic ctrl_wr_c;
  logic stat_rd_c;
  assign data_wr_c = bus_sel && bus_wr && !bus_addr;
  assign ctrl_wr_c = bus_sel && bus_wr &&  bus_addr;
  assign stat_rd_c = bus_sel && !bus_wr && !bus_addr;

  assert_auto_start_R2: assert property (@(posedge clk) disable iff (rst)
    data_wr_c && !mode_manual |=> !strobe_n && (pdata == $past(bus_wdata)));

  assert_manual_level_R6: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_wr_c) && $past(bus_wdata[0]) |=> strobe_n == !$past(bus_wdata[2], 2));

  assert_prime_follow_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_c |=> prime_o == $past(bus_wdata[3]));

  assert_status_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    stat_rd_c |=> bus_rdata[2:0] == 3'b000);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !strobe_n && !$past(strobe_n) && !$past(data_wr_c) |-> pdata == $past(pdata));

endmodule

bind pport_strobe_top pport_strobe_checker u_checker (
  .clk         (clk),
  .rst         (rst),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pdata       (pdata),
  .strobe_n    (strobe_n),
  .prime_o     (prime_o),
  .mode_manual (ctrl_q.manual)
);

// File: tb/pport_strobe_top_tb_top.sv
`timescale 1ns/1ps
module pport_strobe_top_tb_top;

  localparam int CLK_HZ = 10_000_000;
  localparam int W_SLOW = 64;
  localparam int W_FAST = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       prn_busy = 1'b0;
  logic       prn_paper_empty = 1'b0;
  logic       prn_select = 1'b0;
  logic       prn_fault = 1'b0;
  logic       prn_ack = 1'b0;
  logic [7:0] pdata;
  logic       strobe_n;
  logic       prime_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pport_strobe_top #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prn_busy(prn_busy), .prn_paper_empty(prn_paper_empty),
    .prn_select(prn_select), .prn_fault(prn_fault), .prn_ack(prn_ack),
    .pdata(pdata), .strobe_n(strobe_n), .prime_o(prime_o)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic bus_write(input logic addr, input logic [7:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = val;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic addr, output logic [7:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    @(negedge clk);
    bus_sel = 1'b0;
    val = bus_rdata;
  endtask

  // called right after a write returns; counts negedges with strobe_n low
  task automatic measure_low(output int n);
    n = 0;
    while (!strobe_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] r;
    check("R1 strobe_n", strobe_n, 1);
    check("R1 prime_o", prime_o, 0);
    check("R1 pdata", pdata, 8'h00);
    bus_read(1'b1, r);
    check("R1 ctrl readback", r, 8'h00);
  endtask

  task automatic t_auto_slow;
    int n;
    bus_write(1'b0, 8'hA5);
    check("R2 pdata", pdata, 8'hA5);
    check("R2 strobe low", strobe_n, 0);
    measure_low(n);
    check("R3 slow width", n, W_SLOW);
    check("R10 pdata held", pdata, 8'hA5);
  endtask

  task automatic t_auto_fast;
    int n;
    logic [7:0] r;
    bus_write(1'b1, 8'h02);
    bus_read(1'b1, r);
    check("R9 ctrl readback fast", r, 8'h02);
    bus_write(1'b0, 8'h3C);
    check("R2 pdata fast", pdata, 8'h3C);
    measure_low(n);
    check("R4 fast width", n, W_FAST);
    bus_write(1'b1, 8'h00);
  endtask

  task automatic t_retrigger;
    int n;
    bus_write(1'b0, 8'h11);
    repeat (9) @(negedge clk);
    check("R5 still low", strobe_n, 0);
    bus_write(1'b0, 8'h22);
    check("R5 pdata updated", pdata, 8'h22);
    measure_low(n);
    check("R5 restarted width", n, W_SLOW);
  endtask

  task automatic t_manual;
    int n;
    logic [7:0] r;
    bus_write(1'b1, 8'h01);
    @(negedge clk);
    check("R6 manual idle high", strobe_n, 1);
    bus_write(1'b0, 8'h5A);
    check("R6 manual pdata", pdata, 8'h5A);
    check("R6 no pulse", strobe_n, 1);
    repeat (3) @(negedge clk);
    check("R6 still no pulse", strobe_n, 1);
    bus_write(1'b1, 8'h05);
    @(negedge clk);
    check("R6 manual drive low", strobe_n, 0);
    bus_read(1'b1, r);
    check("R9 ctrl readback manual", r, 8'h05);
    bus_write(1'b1, 8'h01);
    @(negedge clk);
    check("R6 manual release", strobe_n, 1);
    // cancel an automatic pulse by entering manual mode
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h77);
    repeat (4) @(negedge clk);
    bus_write(1'b1, 8'h01);
    @(negedge clk);
    check("R6 cancel pulse", strobe_n, 1);
    repeat (W_SLOW) @(negedge clk);
    check("R6 stays high", strobe_n, 1);
    bus_write(1'b1, 8'h00);
    @(negedge clk);
    measure_low(n);
    check("R6 no pulse after return to auto", n, 0);
  endtask

  task automatic t_prime;
    bus_write(1'b1, 8'h08);
    check("R7 prime on", prime_o, 1);
    bus_write(1'b1, 8'h00);
    check("R7 prime off", prime_o, 0);
  endtask

  task automatic t_status;
    logic [7:0] r;
    prn_busy = 1; prn_paper_empty = 0; prn_select = 0; prn_fault = 0; prn_ack = 0;
    repeat (4) @(negedge clk);
    bus_read(1'b0, r);
    check("R8 busy", r, 8'h08);
    prn_busy = 0; prn_fault = 1; prn_ack = 1;
    repeat (4) @(negedge clk);
    bus_read(1'b0, r);
    check("R8 fault ack", r, 8'hC0);
    prn_fault = 0; prn_ack = 0; prn_paper_empty = 1; prn_select = 1;
    repeat (4) @(negedge clk);
    bus_read(1'b0, r);
    check("R8 pe select", r, 8'h30);
    prn_busy = 1; prn_fault = 1; prn_ack = 1;
    repeat (4) @(negedge clk);
    bus_read(1'b0, r);
    check("R8 all", r, 8'hF8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_auto_slow();
    t_auto_fast();
    t_retrigger();
    t_manual();
    t_prime();
    t_status();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule